// File: doc/BRIEF.md
# Mode Pin Register Load and Low-Power Entry Controller

This block watches an active-low mode pin that serves two purposes. A falling edge on the pin opens a write-arrival window of fixed length. If a complete write command reaches the bus before the window closes, the next rising edge of write-enable copies the low address bits into a configuration register and pulses an update strobe. If no such command arrives in time, the block raises a flag that asks the memory to enter partial-array self-refresh. The flag stays up until the pin is released.

Separately, the block monitors ordinary bus writes made while the pin is high. It reports two conditions. The first is that the most recent asynchronous write has not yet been committed by a following write. The second is a forbidden change from a synchronous burst write straight to an asynchronous write. The window length is a cycle count derived from the clock period and a time in nanoseconds.

All inputs are synchronous to `clk`. There is no streaming data path, so no valid/ready handshake is used. Every output is a plain level or a one-cycle pulse, and there is no back-pressure.

Top module: `mpe_ctrl`

## Requirements
- R1: While `rst_n` is low, `cfg_o` equals parameter `RST_CFG` and `cfg_upd_o`, `par_o`, `stale_o` and `seq_err_o` are all 0.
- R2: A clock edge that samples `mode_n` low after it was sampled high opens a window of WIN_CYC = WINDOW_NS*1000/CLK_PERIOD_PS cycles. The window covers the WIN_CYC edges that follow the opening edge.
- R3: A write command is `cs_n`, `adv_n`, both bits of `be_n` and `we_n` all low with `oe_n` high. When such a command is sampled inside the window, the next sampled rising edge of `we_n` (with `cs_n` low, `oe_n` high and `mode_n` still low) loads `addr[CFG_W-1:0]` into `cfg_o` and raises `cfg_upd_o` for exactly one cycle. `cfg_o` changes at no other time.
- R4: A command with `oe_n` low is not a write command and does not prevent the window from expiring.
- R5: If no write command is sampled on any window edge, `par_o` rises right after the last window edge (WIN_CYC edges after the opening edge). A command sampled on that last edge still wins, and the load proceeds with `par_o` staying 0.
- R6: `par_o` stays 1 while `mode_n` is sampled low and clears on the first edge that samples `mode_n` high. Writes made while `par_o` is 1 leave `cfg_o` unchanged.
- R7: If `mode_n` is sampled high before a write command arrives, the window is abandoned. Neither a load nor `par_o` follows.
- R8: A bus write is a sampled rising edge of `we_n` with `cs_n` low and `mode_n` high. It is asynchronous when `sync_mode` is 0 and synchronous when it is 1. `stale_o` becomes 1 after an asynchronous write and 0 after a synchronous one.
- R9: An asynchronous bus write whose previous bus write was synchronous raises `seq_err_o` for exactly one cycle, updated on the same edge as `stale_o`.
- R10: Synchronous-to-synchronous and asynchronous-to-asynchronous bus write sequences never raise `seq_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_n | input | 1 | Active-low dual-purpose mode pin |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address valid, active low |
| be_n | input | LANES | Byte enables, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Address bus |
| sync_mode | input | 1 | 1 when bus writes are synchronous bursts |
| cfg_o | output | CFG_W | Configuration register value |
| cfg_upd_o | output | 1 | One-cycle pulse when `cfg_o` is loaded |
| par_o | output | 1 | Partial-array refresh requested |
| stale_o | output | 1 | Last asynchronous write not yet committed |
| seq_err_o | output | 1 | Pulse on a prohibited synchronous-to-asynchronous write change |

## Verification
Two functions can fall in the same cycle: accepting a write command and expiring the window. Both are decided on the last window edge. The bench drives a write command so that it is first sampled exactly on that edge and expects a load with `par_o` held at 0. It then repeats the sequence with the command one edge later and expects `par_o` to rise and no load to follow. In both runs a scoreboard queue decides whether an update strobe was due, so an unexpected strobe is also caught.

// File: rtl/mpe_pkg.sv
package mpe_pkg;
  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ARMED = 2'd1,
    LD_LOAD  = 2'd2,
    LD_PAR   = 2'd3
  } ld_state_t;

  typedef struct packed {
    logic wr_cmd;
    logic we_rise;
    logic pin_fall;
    logic pin_low;
    logic cs_act;
    logic oe_off;
  } bus_evt_t;
endpackage

// File: rtl/mpe_pin_sampler.sv
module mpe_pin_sampler #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_n,
  input  logic             cs_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] be_n,
  input  logic             we_n,
  input  logic             oe_n,
  output mpe_pkg::bus_evt_t evt
);
  logic we_q;
  logic mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b1;
      mode_q <= 1'b1;
    end else begin
      we_q   <= we_n;
      mode_q <= mode_n;
    end
  end

  always_comb begin
    evt.pin_low  = !mode_n;
    evt.pin_fall = mode_q && !mode_n;
    evt.we_rise  = !we_q && we_n;
    evt.cs_act   = !cs_n;
    evt.oe_off   = oe_n;
    evt.wr_cmd   = !cs_n && !adv_n && !(|be_n) && !we_n && oe_n;
  end
endmodule

// File: rtl/mpe_window_timer.sv
module mpe_window_timer #(
  parameter int WIN_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYC - 1);

  logic [CW-1:0] cnt;

  assign expired = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mpe_load_fsm.sv
module mpe_load_fsm #(
  parameter int ADDR_W = 22,
  parameter int CFG_W = 13,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mpe_pkg::bus_evt_t evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              expired,
  output logic              run,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              cfg_upd_o,
  output logic              par_o
);
  import mpe_pkg::*;

  ld_state_t st, st_nx;
  logic      capture;

  assign run     = (st == LD_ARMED);
  assign capture = (st == LD_LOAD) && evt.pin_low && evt.we_rise
                   && evt.cs_act && evt.oe_off;

  always_comb begin
    st_nx = st;
    unique case (st)
      LD_IDLE:  if (evt.pin_fall) st_nx = LD_ARMED;
      LD_ARMED: begin
        if (!evt.pin_low)     st_nx = LD_IDLE;
        else if (evt.wr_cmd)  st_nx = LD_LOAD;
        else if (expired)     st_nx = LD_PAR;
      end
      LD_LOAD: begin
        if (!evt.pin_low || capture) st_nx = LD_IDLE;
      end
      LD_PAR:   if (!evt.pin_low) st_nx = LD_IDLE;
      default:  st_nx = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= LD_IDLE;
      cfg_o     <= RST_CFG;
      cfg_upd_o <= 1'b0;
      par_o     <= 1'b0;
    end else begin
      st        <= st_nx;
      cfg_upd_o <= capture;
      par_o     <= (st_nx == LD_PAR);
      if (capture) cfg_o <= addr[CFG_W-1:0];
    end
  end
endmodule

// File: rtl/mpe_write_guard.sv
module mpe_write_guard (
  input  logic              clk,
  input  logic              rst_n,
  input  mpe_pkg::bus_evt_t evt,
  input  logic              sync_mode,
  output logic              stale_o,
  output logic              seq_err_o
);
  logic wr_done;
  logic wr_async;
  logic wr_sync;
  logic prev_sync;

  assign wr_done  = evt.we_rise && evt.cs_act && !evt.pin_low;
  assign wr_async = wr_done && !sync_mode;
  assign wr_sync  = wr_done && sync_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stale_o   <= 1'b0;
      prev_sync <= 1'b0;
      seq_err_o <= 1'b0;
    end else begin
      seq_err_o <= wr_async && prev_sync;
      if (wr_async) begin
        stale_o   <= 1'b1;
        prev_sync <= 1'b0;
      end else if (wr_sync) begin
        stale_o   <= 1'b0;
        prev_sync <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpe_ctrl.sv
module mpe_ctrl #(
  parameter int ADDR_W = 22,
  parameter int CFG_W = 13,
  parameter int LANES = 2,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int WINDOW_NS = 500,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic [LANES-1:0]  be_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sync_mode,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              cfg_upd_o,
  output logic              par_o,
  output logic              stale_o,
  output logic              seq_err_o
);
  localparam int RAW_CYC = (WINDOW_NS * 1000) / CLK_PERIOD_PS;
  localparam int WIN_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

  mpe_pkg::bus_evt_t evt;
  logic run;
  logic expired;

  mpe_pin_sampler #(.LANES(LANES)) u_smp (
    .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .cs_n(cs_n),
    .adv_n(adv_n), .be_n(be_n), .we_n(we_n), .oe_n(oe_n), .evt(evt)
  );

  mpe_window_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(run), .expired(expired)
  );

  mpe_load_fsm #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .RST_CFG(RST_CFG)) u_fsm (
    .clk(clk), .rst_n(rst_n), .evt(evt), .addr(addr), .expired(expired),
    .run(run), .cfg_o(cfg_o), .cfg_upd_o(cfg_upd_o), .par_o(par_o)
  );

  mpe_write_guard u_grd (
    .clk(clk), .rst_n(rst_n), .evt(evt), .sync_mode(sync_mode),
    .stale_o(stale_o), .seq_err_o(seq_err_o)
  );
endmodule

// File: rtl/mpe_ctrl_chk.sv
module mpe_ctrl_chk #(
  parameter int ADDR_W = 22,
  parameter int CFG_W = 13,
  parameter int LANES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_n,
  input logic              we_n,
  input logic              sync_mode,
  input logic [CFG_W-1:0]  cfg_o,
  input logic              cfg_upd_o,
  input logic              par_o,
  input logic              stale_o,
  input logic              seq_err_o
);
  p_par_pin_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    par_o |-> $past(!mode_n));

  p_upd_we_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd_o |-> ($past(we_n) && !$past(we_n, 2)));

  p_upd_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd_o |-> $past(!mode_n));

  p_upd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd_o |=> !cfg_upd_o);

  p_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd_o |-> $stable(cfg_o));

  p_no_upd_in_par_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_upd_o && par_o));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |=> !seq_err_o);

  p_err_async_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err_o |-> ($past(!sync_mode) && stale_o));

  p_stale_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stale_o && !$past(stale_o)) |-> $past(!sync_mode && mode_n));
endmodule

bind mpe_ctrl mpe_ctrl_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .we_n(we_n),
  .sync_mode(sync_mode), .cfg_o(cfg_o), .cfg_upd_o(cfg_upd_o),
  .par_o(par_o), .stale_o(stale_o), .seq_err_o(seq_err_o)
);

// File: tb/mpe_ctrl_test.sv
module mpe_ctrl_test;
  localparam int CLK_NS = 10;
  localparam int ADDR_W = 22;
  localparam int CFG_W = 13;
  localparam int WIN = 8;
  localparam logic [CFG_W-1:0] RST_CFG = 13'h0021;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_n = 1'b1, cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0] be_n = 2'b11;
  logic [ADDR_W-1:0] addr = '0;
  logic sync_mode = 1'b0;
  logic [CFG_W-1:0] cfg_o;
  logic cfg_upd_o, par_o, stale_o, seq_err_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [CFG_W-1:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  mpe_ctrl #(.ADDR_W(ADDR_W), .CFG_W(CFG_W), .LANES(2),
             .CLK_PERIOD_PS(CLK_NS*1000), .WINDOW_NS(WIN*CLK_NS),
             .RST_CFG(RST_CFG)) uut (
    .clk(clk), .rst_n(rst_n), .mode_n(mode_n), .cs_n(cs_n), .adv_n(adv_n),
    .be_n(be_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .sync_mode(sync_mode),
    .cfg_o(cfg_o), .cfg_upd_o(cfg_upd_o), .par_o(par_o),
    .stale_o(stale_o), .seq_err_o(seq_err_o)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_bus();
    cs_n = 1'b1; adv_n = 1'b1; be_n = 2'b11; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic drive_cmd(logic [ADDR_W-1:0] a, logic oe);
    cs_n = 1'b0; adv_n = 1'b0; be_n = 2'b00; we_n = 1'b0; oe_n = oe; addr = a;
  endtask

  task automatic wr_pulse();
    cs_n = 1'b0; adv_n = 1'b0; be_n = 2'b00; we_n = 1'b0; oe_n = 1'b1;
    step();
    we_n = 1'b1;
    step();
  endtask

  // scoreboard monitor: every update strobe must match a queued expectation
  always @(negedge clk) begin
    if (rst_n && cfg_upd_o) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected cfg_upd_o", 1, 0);
      end else begin
        logic [CFG_W-1:0] e;
        e = exp_q.pop_front();
        chk("R3 loaded cfg_o", int'(cfg_o), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 cfg_o", int'(cfg_o), int'(RST_CFG));
    chk("R1 cfg_upd_o", int'(cfg_upd_o), 0);
    chk("R1 par_o", int'(par_o), 0);
    chk("R1 stale_o", int'(stale_o), 0);
    chk("R1 seq_err_o", int'(seq_err_o), 0);
    rst_n = 1'b1;
    step();

    // R2 R3: plain load soon after the pin falls
    mode_n = 1'b0; step();
    drive_cmd(22'h3F_1A5B, 1'b1); step();
    step();
    exp_q.push_back(13'h1A5B);
    we_n = 1'b1; step();
    chk("R3 strobe seen", int'(cfg_upd_o), 1);
    step();
    chk("R3 strobe one cycle", int'(cfg_upd_o), 0);
    chk("R3 stale untouched by load", int'(stale_o), 0);
    idle_bus(); mode_n = 1'b1; step(); step();

    // R5 collision: command first sampled on the last window edge wins
    mode_n = 1'b0; step();
    repeat (WIN-1) step();
    chk("R5 no par before window end", int'(par_o), 0);
    drive_cmd(22'h00_0777, 1'b1); step();
    chk("R5 write on last edge keeps par low", int'(par_o), 0);
    step();
    exp_q.push_back(13'h0777);
    we_n = 1'b1; step();
    chk("R5 load after last-edge write", int'(cfg_o), 13'h0777);
    idle_bus(); mode_n = 1'b1; step(); step();

    // R5 R2 timeout: one edge later the window has expired
    mode_n = 1'b0; step();
    repeat (WIN-1) step();
    chk("R2 par low on edge WIN-1", int'(par_o), 0);
    step();
    chk("R5 par high after WIN edges", int'(par_o), 1);
    drive_cmd(22'h00_1234, 1'b1); step();
    we_n = 1'b1; step();
    chk("R6 cfg unchanged while par", int'(cfg_o), 13'h0777);
    chk("R6 par held while pin low", int'(par_o), 1);
    idle_bus(); mode_n = 1'b1; step();
    chk("R6 par cleared by pin high", int'(par_o), 0);
    step();

    // R4: command with oe_n low does not count
    mode_n = 1'b0; step();
    drive_cmd(22'h00_0ABC, 1'b0);
    repeat (WIN) step();
    chk("R4 oe low lets window expire", int'(par_o), 1);
    we_n = 1'b1; step();
    chk("R4 cfg unchanged", int'(cfg_o), 13'h0777);
    idle_bus(); mode_n = 1'b1; step(); step();

    // R7: pin released before any command
    mode_n = 1'b0; step(); step();
    mode_n = 1'b1; step();
    repeat (WIN+2) step();
    chk("R7 abandoned window no par", int'(par_o), 0);
    chk("R7 abandoned window no load", int'(cfg_o), 13'h0777);

    // R8 R9 R10: bus write ordering
    sync_mode = 1'b0;
    wr_pulse();
    chk("R8 stale after async", int'(stale_o), 1);
    chk("R10 no err async first", int'(seq_err_o), 0);
    idle_bus(); step();
    wr_pulse();
    chk("R10 async-async no err", int'(seq_err_o), 0);
    chk("R8 stale after second async", int'(stale_o), 1);
    idle_bus(); step();
    sync_mode = 1'b1;
    wr_pulse();
    chk("R8 sync write clears stale", int'(stale_o), 0);
    idle_bus(); step();
    wr_pulse();
    chk("R10 sync-sync no err", int'(seq_err_o), 0);
    idle_bus(); step();
    sync_mode = 1'b0;
    wr_pulse();
    chk("R9 sync-async err", int'(seq_err_o), 1);
    chk("R9 stale with err", int'(stale_o), 1);
    idle_bus(); step();
    chk("R9 err one cycle", int'(seq_err_o), 0);
    wr_pulse();
    chk("R10 async after err no err", int'(seq_err_o), 0);
    idle_bus(); step(); step();

    chk("R3 all expected loads seen", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule